// File: doc/BRIEF.md
# Video Line and Field Timing Recovery

This block rebuilds the line, field and active-picture timing of a 1080i or 720p high-definition stream. It can take that timing from two places. The first is the timing reference codes embedded in the 10-bit luma samples. The second is a set of separate sync pins: a horizontal sync, a vertical sync and a data-valid strobe whose polarity can be programmed. A 2-bit source field selects between these two inputs at run time. One further code of that field is reserved and turns the block quiet.

A downstream sync inserter or scaler uses the outputs. There is a one-cycle horizontal reference pulse and a running line number. There are field and vertical-blank flags and an active-picture flag. A one-cycle pulse reports that the line counter was reset by the timing-reset control bit. The luma stream carries one sample on every clock and has no back-pressure, because a video source cannot pause. For this reason the sample input is a plain bus and has no valid/ready pair. All control and status pins are plain levels.

Top module: `vid_timing_recover`

## Requirements
- R1: While reset is held and just after it is released, with `src_mode` = 01: `href`, `active`, `field`, `vblank` and `tmr_clr` are 0 and `line_no` is 1.
- R2: In embedded mode (`src_mode` = 01), a timing reference is the four consecutive samples 3FFh, 000h, 000h and a status word. The status word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bits 5..2 = protection and bits 1..0 = 0. A status word with H = 1 (end of active) raises `href` for exactly one cycle, starting at the clock edge that samples the status word.
- R3: In embedded mode, at each end-of-active code `field` takes F and `vblank` takes V, and `active` drops to 0. At each start-of-active code (H = 0), `active` becomes the inverse of that code's V bit.
- R4: In embedded mode, `line_no` advances by one at each end-of-active code. After the last line of the frame (1125 for 1080i, 750 for 720p) it wraps to 1.
- R5: In embedded mode, an end-of-active code whose F or V differs from the previous end-of-active code loads `line_no` with the line that starts that change. For 1080i: F rising loads 563, F falling loads 1, V rising loads 561 in field 0 or 1124 in field 1, and V falling loads 21 in field 0 or 584 in field 1. For 720p: V rising loads 746 and V falling loads 26.
- R6: In pin modes (`src_mode` = 00 or 10), a falling edge on `hsync_n` pulses `href` for one cycle and advances `line_no` as in R4. A falling edge on `vsync_n` sets `line_no` to 1, and this takes priority over a horizontal edge in the same cycle.
- R7: In pin modes with 1080i selected, `field` is 1 on lines 563..1125. `vblank` is 1 on lines 1..20, 561..583 and 1124..1125.
- R8: In pin modes, `active` is registered from `dv_in`. With `dv_pol` = 0 the strobe is active high; with `dv_pol` = 1 it is active low.
- R9: A high-to-low change of `tmr_rst_bit` sets `line_no` to 1 and pulses `tmr_clr` for one cycle. While the bit is held high, the counter is not touched.
- R10: With `src_mode` = 11 (reserved), `href`, `active`, `field` and `vblank` are 0 from the next cycle on, and `line_no` holds its value.
- R11: With `std_720p` = 1, `field` is 0 in pin modes. `vblank` is 1 on lines 1..25 and 746..750.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| y_in | input | 10 | Luma sample, one per clock |
| hsync_n | input | 1 | Horizontal sync pin, active low |
| vsync_n | input | 1 | Vertical sync pin, active low |
| dv_in | input | 1 | Data-valid strobe pin |
| src_mode | input | 2 | Timing source: 00 pins, 01 embedded, 10 async pins, 11 reserved |
| std_720p | input | 1 | 0 selects 1080i, 1 selects 720p |
| dv_pol | input | 1 | Strobe polarity: 0 active high, 1 active low |
| tmr_rst_bit | input | 1 | Timing-reset control bit; acts on its falling edge |
| href | output | 1 | One-cycle horizontal reference pulse |
| field | output | 1 | Field flag |
| vblank | output | 1 | Vertical blanking flag |
| active | output | 1 | Active-picture flag |
| line_no | output | 11 | Current line number, 1-based |
| tmr_clr | output | 1 | One-cycle pulse on a timing reset |

## Verification
A wrong line count shows on `line_no` at the very next end-of-active code or horizontal sync edge. In pin modes it also shows on `field` and `vblank` within the same line, because those flags are decoded from the count. A fault in the four-sample code history shows within four samples, as a missing or extra `href` pulse and a stale `active`. A wrong reload value stays visible until the next F/V transition, so the bench sweeps full frame boundaries in both standards.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
  localparam int LW = 11;

  typedef enum logic [1:0] {
    SRC_PINS  = 2'b00,
    SRC_EMBED = 2'b01,
    SRC_ASYNC = 2'b10,
    SRC_RSVD  = 2'b11
  } src_mode_e;

  function automatic logic [LW-1:0] frame_last(input logic s720);
    return s720 ? LW'(750) : LW'(1125);
  endfunction

  function automatic logic tab_field(input logic s720, input logic [LW-1:0] ln);
    return !s720 && (ln >= LW'(563));
  endfunction

  function automatic logic tab_vblank(input logic s720, input logic [LW-1:0] ln);
    if (s720) return (ln <= LW'(25)) || (ln >= LW'(746));
    return (ln <= LW'(20)) || ((ln >= LW'(561)) && (ln <= LW'(583))) || (ln >= LW'(1124));
  endfunction

  // Line that begins a given F/V transition.
  function automatic logic [LW-1:0] reload_line(input logic s720, input logic f,
                                                input logic v, input logic fp);
    if (f != fp)  return f ? LW'(563) : LW'(1);
    if (v)        return s720 ? LW'(746) : (f ? LW'(1124) : LW'(561));
    return s720 ? LW'(26) : (f ? LW'(584) : LW'(21));
  endfunction
endpackage

// File: rtl/vtr_trs_detect.sv
module vtr_trs_detect #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word,
  output logic          hit,
  output logic          fbit,
  output logic          vbit,
  output logic          hbit
);
  logic [DW-1:0] w1, w2, w3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= '0;
      w2 <= '0;
      w3 <= '0;
    end else begin
      w3 <= w2;
      w2 <= w1;
      w1 <= word;
    end
  end

  assign hit  = (w3 == '1) && (w2 == '0) && (w1 == '0) && word[DW-1];
  assign fbit = word[DW-2];
  assign vbit = word[DW-3];
  assign hbit = word[DW-4];
endmodule

// File: rtl/vtr_pin_edges.sv
module vtr_pin_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hs_n,
  input  logic vs_n,
  output logic hs_fall,
  output logic vs_fall
);
  logic hs_q, vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hs_n;
      vs_q <= vs_n;
    end
  end

  assign hs_fall = en && hs_q && !hs_n;
  assign vs_fall = en && vs_q && !vs_n;
endmodule

// File: rtl/vtr_line_ctr.sv
module vtr_line_ctr #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          step,
  input  logic [LW-1:0] last,
  output logic [LW-1:0] line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line <= LW'(1);
    else if (clr)         line <= LW'(1);
    else if (load)        line <= load_val;
    else if (step)        line <= (line == last) ? LW'(1) : line + LW'(1);
  end

  a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clr && line != last) |=> line == LW'($past(line) + 1'b1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clr && line == last) |=> line == LW'(1));

  a_r9_clear_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> line == LW'(1));
endmodule

// File: rtl/vid_timing_recover.sv
module vid_timing_recover
  import vtr_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] y_in,
  input  logic          hsync_n,
  input  logic          vsync_n,
  input  logic          dv_in,
  input  logic [1:0]    src_mode,
  input  logic          std_720p,
  input  logic          dv_pol,
  input  logic          tmr_rst_bit,
  output logic          href,
  output logic          field,
  output logic          vblank,
  output logic          active,
  output logic [LW-1:0] line_no,
  output logic          tmr_clr
);
  src_mode_e mode;
  logic emb, pin;
  logic hit, fb, vb, hb, eav, sav;
  logic hs_fall, vs_fall;
  logic tr_q, clr_ev;
  logic [1:0] fv_q;
  logic fv_seen, fv_chg;
  logic ld;
  logic [LW-1:0] ld_val;
  logic href_r, fld_r, vbl_r, act_r, clr_r;

  assign mode = src_mode_e'(src_mode);
  assign emb  = (mode == SRC_EMBED);
  assign pin  = (mode == SRC_PINS) || (mode == SRC_ASYNC);

  vtr_trs_detect #(.DW(DW)) u_trs (
    .clk(clk), .rst_n(rst_n), .word(y_in),
    .hit(hit), .fbit(fb), .vbit(vb), .hbit(hb)
  );

  vtr_pin_edges u_pins (
    .clk(clk), .rst_n(rst_n), .en(pin),
    .hs_n(hsync_n), .vs_n(vsync_n),
    .hs_fall(hs_fall), .vs_fall(vs_fall)
  );

  assign eav    = emb && hit && hb;
  assign sav    = emb && hit && !hb;
  assign clr_ev = tr_q && !tmr_rst_bit;
  assign fv_chg = fv_seen && ({fb, vb} != fv_q);
  assign ld     = (eav && fv_chg) || vs_fall;
  assign ld_val = vs_fall ? LW'(1) : reload_line(std_720p, fb, vb, fv_q[1]);

  vtr_line_ctr #(.LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .load(ld), .load_val(ld_val),
    .step(eav || hs_fall), .last(frame_last(std_720p)), .line(line_no)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_q    <= 1'b0;
      clr_r   <= 1'b0;
      href_r  <= 1'b0;
      fv_q    <= 2'b00;
      fv_seen <= 1'b0;
      fld_r   <= 1'b0;
      vbl_r   <= 1'b0;
      act_r   <= 1'b0;
    end else begin
      tr_q   <= tmr_rst_bit;
      clr_r  <= clr_ev;
      href_r <= eav || hs_fall;
      if (clr_ev) fv_seen <= 1'b0;
      else if (eav) begin
        fv_q    <= {fb, vb};
        fv_seen <= 1'b1;
      end
      unique case (mode)
        SRC_EMBED: begin
          if (eav) begin
            fld_r <= fb;
            vbl_r <= vb;
            act_r <= 1'b0;
          end else if (sav) begin
            act_r <= !vb;
          end
        end
        SRC_PINS, SRC_ASYNC: act_r <= dv_in ^ dv_pol;
        default: begin
          fld_r <= 1'b0;
          vbl_r <= 1'b0;
          act_r <= 1'b0;
        end
      endcase
    end
  end

  assign href    = href_r;
  assign active  = act_r;
  assign tmr_clr = clr_r;
  assign field   = pin ? tab_field(std_720p, line_no)  : fld_r;
  assign vblank  = pin ? tab_vblank(std_720p, line_no) : vbl_r;

  a_r2_href_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    href |=> !href);

  a_r3_eav_ends_active: assert property (@(posedge clk) disable iff (!rst_n)
    eav |=> !active);

  a_r9_pulse_line_one: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> line_no == LW'(1));

  a_r10_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_RSVD) |=> (src_mode != 2'b11 || (!href && !active && !field && !vblank)));
endmodule

// File: tb/test_vid_timing_recover.sv
module test_vid_timing_recover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] y_in = 10'h040;
  logic hsync_n = 1'b1, vsync_n = 1'b1, dv_in = 1'b0;
  logic [1:0] src_mode = 2'b01;
  logic std_720p = 1'b0, dv_pol = 1'b0, tmr_rst_bit = 1'b0;
  logic href, field, vblank, active, tmr_clr;
  logic [10:0] line_no;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  vid_timing_recover i_vid_timing_recover (
    .clk(clk), .rst_n(rst_n), .y_in(y_in), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .dv_in(dv_in), .src_mode(src_mode), .std_720p(std_720p), .dv_pol(dv_pol),
    .tmr_rst_bit(tmr_rst_bit), .href(href), .field(field), .vblank(vblank),
    .active(active), .line_no(line_no), .tmr_clr(tmr_clr)
  );

  always #4 clk = ~clk;

  function automatic bit ef(input bit s720, input int ln);
    return !s720 && ln >= 563;
  endfunction

  function automatic bit ev(input bit s720, input int ln);
    if (s720) return ln <= 25 || ln >= 746;
    return ln <= 20 || (ln >= 561 && ln <= 583) || ln >= 1124;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] w);
    y_in = w;
    tick();
  endtask

  task automatic send_trs(input bit f, input bit v, input bit h);
    send(10'h3FF);
    send(10'h000);
    send(10'h000);
    send({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00});
  endtask

  bit locked;
  bit have_prev;
  bit pf, pv;

  task automatic emb_line(input bit s720, input int ln);
    bit f, v, chg;
    f = ef(s720, ln);
    v = ev(s720, ln);
    chg = have_prev && (f != pf || v != pv);
    if (chg) locked = 1;
    have_prev = 1;
    pf = f;
    pv = v;
    send_trs(f, v, 1'b1);
    check("R2 href at end-of-active", href, 1);
    check("R3 field from code", field, f);
    check("R3 vblank from code", vblank, v);
    check("R3 active off at end-of-active", active, 0);
    if (locked) check(chg ? "R5 line reload" : "R4 line advance", line_no, ln);
    send(10'h040 + 10'($urandom % 768));
    check("R2 href one cycle", href, 0);
    for (int i = 0; i < 5; i++) send(10'h040 + 10'($urandom % 768));
    send_trs(f, v, 1'b0);
    check("R3 active after start-of-active", active, !v);
    for (int i = 0; i < 6; i++) send(10'h004 + 10'($urandom % 1016));
  endtask

  int pline;

  task automatic pin_line(input bit s720, input bit do_vs);
    hsync_n = 1'b0;
    vsync_n = do_vs ? 1'b0 : 1'b1;
    tick();
    pline = do_vs ? 1 : pline + 1;
    check("R6 href on hsync edge", href, 1);
    check("R6 line from pins", line_no, pline);
    check(s720 ? "R11 field table" : "R7 field table", field, ef(s720, pline));
    check(s720 ? "R11 vblank table" : "R7 vblank table", vblank, ev(s720, pline));
    hsync_n = 1'b1;
    vsync_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bit d, p;
      d = 1'($urandom);
      p = 1'($urandom);
      dv_in = d;
      dv_pol = p;
      tick();
      check("R8 active from strobe", active, d ^ p);
    end
  endtask

  initial begin
    void'($urandom(32'd1973));
    #3;
    @(posedge clk);
    #2;
    check("R1 href reset", href, 0);
    check("R1 line reset", line_no, 1);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 href", href, 0);
    check("R1 active", active, 0);
    check("R1 field", field, 0);
    check("R1 vblank", vblank, 0);
    check("R1 tmr_clr", tmr_clr, 0);
    check("R1 line", line_no, 1);

    // embedded 1080i: lock at line 561, run through the frame wrap
    locked = 0; have_prev = 0;
    for (int ln = 400; ln <= 1125; ln++) emb_line(1'b0, ln);
    for (int ln = 1; ln <= 30; ln++) emb_line(1'b0, ln);

    // embedded 720p: lock at 746, plain wrap 750 -> 1, reload at 26
    std_720p = 1'b1;
    locked = 0; have_prev = 0;
    for (int ln = 700; ln <= 750; ln++) emb_line(1'b1, ln);
    for (int ln = 1; ln <= 30; ln++) emb_line(1'b1, ln);

    // pin mode 1080i
    std_720p = 1'b0;
    src_mode = 2'b00;
    tick();
    pin_line(1'b0, 1'b1);
    for (int i = 0; i < 24; i++) pin_line(1'b0, 1'b0);
    // async pin mode
    src_mode = 2'b10;
    for (int i = 0; i < 4; i++) pin_line(1'b0, 1'b0);

    // timing reset: only the falling edge acts
    tmr_rst_bit = 1'b1;
    tick();
    check("R9 no clear while high", line_no, pline);
    check("R9 no pulse while high", tmr_clr, 0);
    tmr_rst_bit = 1'b0;
    tick();
    check("R9 pulse on fall", tmr_clr, 1);
    check("R9 line cleared", line_no, 1);
    tick();
    check("R9 pulse one cycle", tmr_clr, 0);
    pline = 1;
    pin_line(1'b0, 1'b0);

    // pin mode 720p
    std_720p = 1'b1;
    src_mode = 2'b00;
    pin_line(1'b1, 1'b1);
    for (int i = 0; i < 27; i++) pin_line(1'b1, 1'b0);

    // reserved mode
    src_mode = 2'b11;
    dv_in = 1'b1;
    dv_pol = 1'b0;
    tick();
    send_trs(1'b0, 1'b0, 1'b1);
    check("R10 href quiet", href, 0);
    check("R10 active quiet", active, 0);
    check("R10 field quiet", field, 0);
    check("R10 vblank quiet", vblank, 0);
    check("R10 line held", line_no, pline);
    hsync_n = 1'b0;
    tick();
    check("R10 hsync ignored", href, 0);
    check("R10 line held after hsync", line_no, pline);
    hsync_n = 1'b1;
    tick();

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule